// File: doc/BRIEF.md
# Conditional Trap Comparator

This block decides whether a conditional trap instruction has to raise a program-class exception. It takes two operands and a five-bit condition mask. Five relations are computed side by side: signed less-than, signed greater-than, equality, unsigned less-than and unsigned greater-than. Each mask bit enables one relation, and the trap fires when any enabled relation holds.

A width select chooses the operand form. In the full form all 64 bits are compared. In the word form only the low 32 bits count: they are sign-extended for the signed tests and zero-extended for the unsigned tests and for equality. The result is registered. A request qualified by `in_valid` returns `out_valid` one cycle later, together with the trap flag and a fixed reason code for the exception logic.

Top module: `trap_cond_unit`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it, `out_valid`, `trap_hit` and `trap_code` are all zero.
- R2: `out_valid` equals the value `in_valid` had at the previous rising clock edge.
- R3: Mask bit 4 (value 0x10) traps when `op_a` is less than `op_b` as a two's-complement number.
- R4: Mask bit 3 (value 0x08) traps when `op_a` is greater than `op_b` as a two's-complement number.
- R5: Mask bit 2 (value 0x04) traps when the compared operands are equal.
- R6: Mask bit 1 (value 0x02) traps when `op_a` is less than `op_b` as an unsigned number.
- R7: Mask bit 0 (value 0x01) traps when `op_a` is greater than `op_b` as an unsigned number.
- R8: `trap_hit` is the OR of all enabled relations for the request of the previous cycle. A mask of 0x00 never traps and a mask of 0x1F always traps.
- R9: With `wide_sel`=0 only bits 31:0 of each operand are compared (sign-extended for R3/R4, zero-extended for R5–R7), and bits 63:32 have no effect. With `wide_sel`=1 all 64 bits are compared.
- R10: When `trap_hit` is 1, `trap_code` carries the parameter `TRAP_REASON` (default 4'h2). Otherwise it is 0. `trap_hit` is never 1 while `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Qualifies the operands, mask and width select |
| op_a | input | 64 | First operand |
| op_b | input | 64 | Second operand |
| cond_mask | input | 5 | Relation enables: bit4 signed <, bit3 signed >, bit2 ==, bit1 unsigned <, bit0 unsigned > |
| wide_sel | input | 1 | 1 = compare 64 bits, 0 = compare the low 32 bits |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| trap_hit | output | 1 | A trap must be raised |
| trap_code | output | 4 | Reason code for the exception logic, zero when there is no trap |

## Verification
All three outputs are due exactly one rising edge after the request that causes them, and the block holds no other state. The bench therefore applies a new request 1 ns after each edge. It compares `out_valid`, `trap_hit` and `trap_code` 1 ns after the following edge against the value its reference model computed when that request was applied. Requests run back to back, so every cycle is checked. Idle cycles and word-form requests with differing upper halves are mixed in, which shows that a request never leaks into the next cycle and that the ignored bits stay ignored.

// File: rtl/trap_cmp_pkg.sv
package trap_cmp_pkg;

  localparam int unsigned COND_W = 5;

  // Mask bit positions; the relation vector uses the same order
  localparam int unsigned BIT_SLT = 4;
  localparam int unsigned BIT_SGT = 3;
  localparam int unsigned BIT_EQ  = 2;
  localparam int unsigned BIT_ULT = 1;
  localparam int unsigned BIT_UGT = 0;

  // Packed so that field order matches the mask bit positions above
  typedef struct packed {
    logic slt;
    logic sgt;
    logic eq;
    logic ult;
    logic ugt;
  } trap_rel_t;

  function automatic logic [COND_W-1:0] rel_as_vec(input trap_rel_t r);
    return r;
  endfunction

endpackage

// File: rtl/trap_operand_fold.sv
module trap_operand_fold #(
  parameter int unsigned DATA_W   = 64,
  parameter int unsigned NARROW_W = 32
) (
  input  logic [DATA_W-1:0] raw,
  input  logic              wide,
  output logic [DATA_W-1:0] as_signed,
  output logic [DATA_W-1:0] as_unsigned
);
  localparam int unsigned EXT_W = DATA_W - NARROW_W;

  generate
    if (EXT_W > 0) begin : g_fold
      function automatic logic [DATA_W-1:0] sext_low(input logic [DATA_W-1:0] v);
        return {{EXT_W{v[NARROW_W-1]}}, v[NARROW_W-1:0]};
      endfunction
      function automatic logic [DATA_W-1:0] zext_low(input logic [DATA_W-1:0] v);
        return {{EXT_W{1'b0}}, v[NARROW_W-1:0]};
      endfunction
      assign as_signed   = wide ? raw : sext_low(raw);
      assign as_unsigned = wide ? raw : zext_low(raw);
    end else begin : g_pass
      assign as_signed   = raw;
      assign as_unsigned = raw;
    end
  endgenerate
endmodule

// File: rtl/trap_rel_core.sv
module trap_rel_core
  import trap_cmp_pkg::*;
#(
  parameter int unsigned DATA_W   = 64,
  parameter int unsigned NARROW_W = 32
) (
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic              wide,
  output trap_rel_t         rel
);
  localparam int unsigned N_OPS = 2;

  logic [N_OPS-1:0][DATA_W-1:0] raw_ops;
  logic [N_OPS-1:0][DATA_W-1:0] sgn_ops;
  logic [N_OPS-1:0][DATA_W-1:0] uns_ops;

  assign raw_ops[0] = op_a;
  assign raw_ops[1] = op_b;

  generate
    for (genvar g = 0; g < N_OPS; g++) begin : g_op
      trap_operand_fold #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_fold (
        .raw        (raw_ops[g]),
        .wide       (wide),
        .as_signed  (sgn_ops[g]),
        .as_unsigned(uns_ops[g])
      );
    end
  endgenerate

  function automatic logic signed_less(input logic [DATA_W-1:0] x, input logic [DATA_W-1:0] y);
    return $signed(x) < $signed(y);
  endfunction

  function automatic logic unsigned_less(input logic [DATA_W-1:0] x, input logic [DATA_W-1:0] y);
    return x < y;
  endfunction

  always_comb begin
    rel.slt = signed_less(sgn_ops[0], sgn_ops[1]);
    rel.sgt = signed_less(sgn_ops[1], sgn_ops[0]);
    rel.eq  = (uns_ops[0] == uns_ops[1]);
    rel.ult = unsigned_less(uns_ops[0], uns_ops[1]);
    rel.ugt = unsigned_less(uns_ops[1], uns_ops[0]);
  end
endmodule

// File: rtl/trap_mask_reduce.sv
module trap_mask_reduce
  import trap_cmp_pkg::*;
(
  input  logic [COND_W-1:0] cond_mask,
  input  trap_rel_t         rel,
  output logic [COND_W-1:0] hit_vec,
  output logic              trap_any
);
  assign hit_vec  = cond_mask & rel_as_vec(rel);
  assign trap_any = |hit_vec;
endmodule

// File: rtl/trap_cond_unit.sv
module trap_cond_unit
  import trap_cmp_pkg::*;
#(
  parameter int unsigned DATA_W      = 64,
  parameter int unsigned NARROW_W    = 32,
  parameter int unsigned CODE_W      = 4,
  parameter logic [CODE_W-1:0] TRAP_REASON = 4'h2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic [4:0]        cond_mask,
  input  logic              wide_sel,
  output logic              out_valid,
  output logic              trap_hit,
  output logic [CODE_W-1:0] trap_code
);
  // Named internal events, visible to the assertions below
  trap_rel_t         rel;
  logic [COND_W-1:0] hit_vec;
  logic              trap_any;
  logic              trap_take;

  trap_rel_core #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_core (
    .op_a (op_a),
    .op_b (op_b),
    .wide (wide_sel),
    .rel  (rel)
  );

  trap_mask_reduce u_reduce (
    .cond_mask(cond_mask),
    .rel      (rel),
    .hit_vec  (hit_vec),
    .trap_any (trap_any)
  );

  assign trap_take = in_valid & trap_any;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      trap_hit  <= 1'b0;
      trap_code <= '0;
    end else begin
      out_valid <= in_valid;
      trap_hit  <= trap_take;
      trap_code <= trap_take ? TRAP_REASON : '0;
    end
  end

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R2
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R3 R4
  signed_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> $onehot0({rel.slt, rel.sgt}));
  // R6 R7
  unsigned_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> $onehot0({rel.ult, rel.ugt}));
  // R5
  eq_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && rel.eq) |-> !(rel.slt || rel.sgt || rel.ult || rel.ugt));
  // R8
  zero_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cond_mask == 5'h00) |=> (out_valid && !trap_hit));
  // R8
  full_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cond_mask == 5'h1F) |=> trap_hit);
  // R9
  narrow_eq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !wide_sel && op_a[NARROW_W-1:0] == op_b[NARROW_W-1:0]) |-> rel.eq);
  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!trap_hit && trap_code == '0));
  // R10
  code_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_hit |-> trap_code == TRAP_REASON);
endmodule

// File: tb/trap_cond_unit_bench.sv
module trap_cond_unit_bench;
  localparam logic [3:0] EXP_CODE = 4'h2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] op_a = '0;
  logic [63:0] op_b = '0;
  logic [4:0]  cond_mask = '0;
  logic        wide_sel = 1'b1;
  logic        out_valid;
  logic        trap_hit;
  logic [3:0]  trap_code;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  trap_cond_unit u_trap_cond_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .op_a(op_a), .op_b(op_b), .cond_mask(cond_mask), .wide_sel(wide_sel),
    .out_valid(out_valid), .trap_hit(trap_hit), .trap_code(trap_code)
  );

  // Behavioural reference using native 64-bit integers
  function automatic bit model_trap(input logic [63:0] a, input logic [63:0] b,
                                    input logic [4:0] m, input bit wide);
    longint sa, sb;
    longint unsigned ua, ub;
    if (wide) begin
      sa = a; sb = b; ua = a; ub = b;
    end else begin
      sa = longint'(int'(a[31:0]));
      sb = longint'(int'(b[31:0]));
      ua = longint'(a[31:0]);
      ub = longint'(b[31:0]);
    end
    return (m[4] && sa < sb) || (m[3] && sa > sb) || (m[2] && ua == ub) ||
           (m[1] && ua < ub) || (m[0] && ua > ub);
  endfunction

  task automatic compare(input string tag, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: {valid,trap,code} actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // Drive one request just after an edge; check it just after the next edge
  task automatic step(input bit v, input logic [63:0] a, input logic [63:0] b,
                      input logic [4:0] m, input bit w, input string tag);
    bit t;
    in_valid = v; op_a = a; op_b = b; cond_mask = m; wide_sel = w;
    t = v && model_trap(a, b, m, w);
    @(posedge clk); #1;
    compare(tag, {out_valid, trap_hit, trap_code}, {v, t, t ? EXP_CODE : 4'h0});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: reset dominates a valid request
    in_valid = 1'b1; cond_mask = 5'h1F;
    repeat (3) @(posedge clk);
    #1;
    compare("R1 in reset", {out_valid, trap_hit, trap_code}, 6'b0);
    in_valid = 1'b0;
    rst_n = 1'b1;
    @(posedge clk); #1;
    compare("R1 after reset", {out_valid, trap_hit, trap_code}, 6'b0);

    // R2: idle cycles give no valid even with a full mask
    step(0, 64'd1, 64'd1, 5'h1F, 1, "R2 idle");
    step(1, 64'd1, 64'd1, 5'h04, 1, "R2 valid");
    step(0, 64'd1, 64'd1, 5'h04, 1, "R2 drop");

    // R3/R6: -5 vs 3
    step(1, -64'sd5, 64'd3, 5'h10, 1, "R3 signed lt");
    step(1, -64'sd5, 64'd3, 5'h02, 1, "R6 unsigned not lt");
    step(1, 64'd3, -64'sd5, 5'h02, 1, "R6 unsigned lt");
    // R4/R7
    step(1, 64'd3, -64'sd5, 5'h08, 1, "R4 signed gt");
    step(1, -64'sd5, 64'd3, 5'h08, 1, "R4 signed not gt");
    step(1, -64'sd5, 64'd3, 5'h01, 1, "R7 unsigned gt");
    // R5
    step(1, 64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF0, 5'h04, 1, "R5 equal");
    step(1, 64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF0, 5'h1B, 1, "R5 equal other bits");
    step(1, 64'd7, 64'd8, 5'h04, 1, "R5 not equal");
    // R8
    step(1, 64'd7, 64'd8, 5'h00, 1, "R8 zero mask");
    step(1, 64'd9, 64'd9, 5'h00, 0, "R8 zero mask eq");
    step(1, 64'd9, 64'd9, 5'h1F, 1, "R8 full mask eq");
    step(1, 64'h8000_0000_0000_0000, 64'd0, 5'h1F, 1, "R8 full mask min");
    step(1, 64'd2, 64'd1, 5'h12, 1, "R8 or none true");
    step(1, 64'd2, 64'd1, 5'h13, 1, "R8 or one true");
    // R9: upper halves ignored in word form
    step(1, 64'hFFFF_FFFF_0000_0001, 64'h0000_0000_0000_0001, 5'h04, 0, "R9 narrow eq");
    step(1, 64'hFFFF_FFFF_0000_0001, 64'h0000_0000_0000_0001, 5'h04, 1, "R9 wide neq");
    step(1, 64'h0000_0000_8000_0000, 64'd1, 5'h10, 0, "R9 narrow signed lt");
    step(1, 64'h0000_0000_8000_0000, 64'd1, 5'h10, 1, "R9 wide not lt");
    step(1, 64'h0000_0000_8000_0000, 64'h7FFF_FFFF_0000_0001, 5'h01, 0, "R9 narrow unsigned gt");
    step(1, 64'h0000_0000_0000_0005, 64'hFFFF_FFFF_0000_0005, 5'h0B, 0, "R9 narrow upper ignored");

    // R10 and everything else: mixed random stream
    for (int i = 0; i < 600; i++) begin
      logic [63:0] a, b;
      int sel;
      a = {$urandom, $urandom};
      sel = $urandom_range(0, 3);
      case (sel)
        0: b = a;
        1: b = {$urandom, a[31:0]};
        2: b = a ^ (64'd1 << $urandom_range(0, 63));
        default: b = {$urandom, $urandom};
      endcase
      step(($urandom_range(0, 4) != 0), a, b, 5'($urandom), 1'($urandom), "R10 random");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule